// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the host-facing register core of a two-channel serial communications controller. A byte-wide host bus reaches it with a one-cycle access strobe and a two-bit address. Control accesses on each channel go through an indirect register pointer. The block holds the write and read register files of both channels, tracks receive-available and transmit-empty status, and keeps per-channel interrupt pending and under-service flags. It also maintains a shared interrupt vector and drives a single combined interrupt line.

Serial shifting, baud generation, synchronous modes and DMA are outside this block. Received bytes come in per channel over a valid/ready pair. Bytes written by the host to a data port leave on a per-channel valid strobe. A per-channel break pulse reports a line break. All state updates take effect on the clock edge that samples the access strobe. Read data is returned combinationally during the strobe cycle.

Top module: `dcsr_top`

## Requirements
- R1: Address bit 0 selects control (0) or data (1). Address bit 1 selects the channel: 1 is channel A and 0 is channel B. Each channel has its own pointer and its own registers.
- R2: A control write while the channel pointer is 0 loads pointer bits 2:0 from data bits 2:0 and decodes data bits 5:3 as a command. Command value 1 also sets pointer bit 3, so registers 8 to 15 are reachable.
- R3: A control write with a nonzero pointer stores the data in write register [pointer] and returns the pointer to 0. A control read returns read register [pointer] and returns the pointer to 0. The readable registers are RR0 (status), RR1, RR2, RR12 and RR13; every other index reads 0. On channel B, RR2 is the vector; on channel A it reads 0. RR12 and RR13 mirror the last values written to WR12 and WR13.
- R4: A byte is accepted (ready high) on a channel only under three conditions: WR3 bit 0 is 1, RR0 bit 0 is 0, and no host access is in progress. If both channels offer a byte in the same cycle, channel A is served first. Acceptance stores the byte, sets RR0 bit 0 and raises a receive interrupt.
- R5: A data read returns the stored byte. It clears RR0 bit 0 and clears the receive pending and under-service flags. If a transmit interrupt is pending, that interrupt then becomes under service and its code is placed in the vector.
- R6: A data write sets RR0 bit 2 and RR1 bit 0 and raises a transmit interrupt. One cycle later, the written byte is output with a valid pulse, but only if WR5 bit 3 is 1.
- R7: A receive interrupt is always marked under service and always loads its vector code. A transmit interrupt is marked under service, and loads its code, only when no receive interrupt is under service.
- R8: Command 5 (data 0x28) clears the transmit pending and under-service flags and loads the no-interrupt code. If a receive interrupt is still pending, it is then marked under service again and its code is loaded.
- R9: Command 7 (data 0x38) handles the highest interrupt under service. If a receive interrupt is under service, it clears that flag and re-raises a pending transmit interrupt. Otherwise it clears the transmit under-service flag.
- R10: The vector codes depend on the raising channel's WR9 bit 4, given here as the value with the bit clear / set. Receive A is 0x0C / 0x30, receive B 0x04 / 0x20, transmit A 0x08 / 0x10, and no interrupt 0x06 / 0x60. Transmit B is always 0x00.
- R11: The interrupt output is the OR, over both channels, of three terms: WR1 bit 1 with transmit pending; WR1 bits 4:3 equal to 01 or 10 with receive pending; and WR15 bit 7 with RR0 bit 7.
- R12: A write to WR9 with bits 7:6 nonzero is a reset command and is not stored: 01 resets channel B, 10 resets channel A, 11 resets both. A reset channel gets WR4=0x04, WR9=0xC0, WR11=0x08, WR14=0x30, WR15=0xF8, RR0=0x44, RR1=0x07, with every other register and all interrupt flags at 0. Resetting channel B also clears the vector. When bits 7:6 are 00, the write is stored as WR9.
- R13: A break pulse on a channel sets its RR0 bit 7, which stays set until that channel is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | One-cycle host access strobe |
| hostWrite | input | 1 | 1 for a write, 0 for a read |
| hostAddr | input | 2 | Bit 0 control/data, bit 1 channel (1 = A) |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Read data, valid during the strobe cycle |
| rxValid | input | 2 | Received byte offered, index 1 = A, 0 = B |
| rxData | input | 16 | Received bytes, channel index n at bits 8n+7:8n |
| rxReady | output | 2 | Byte accepted this cycle when paired with rxValid |
| rxBreak | input | 2 | Break detected pulse per channel |
| txValid | output | 2 | Transmit byte strobe per channel |
| txData | output | 16 | Transmit bytes, same packing as rxData |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The in-design assertions check the following on every cycle:
- an under-service flag never exists without its pending flag;
- the pointer comes back to 0 after every nonzero-pointer control access;
- an accepted byte always raises receive-available;
- a reset command always restores the status and WR9 defaults;
- the transmit strobe follows WR5 bit 3.

The ordering rules can only be shown by the bench's scenarios. These include a pending receive interrupt holding off the transmit vector, the receive interrupt being re-marked after a transmit clear, and the release chain through the reset-highest command and data reads. The scenarios also cover the status-high code set, channel A's priority over channel B on simultaneous bytes, and reset of one channel leaving the other untouched.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
  localparam int NCH = 2;
  localparam int DW = 8;
  localparam int NREG = 16;
  localparam int PW = $clog2(NREG);
  localparam int CH_B = 0;
  localparam int CH_A = 1;

  localparam logic [PW-1:0] REG_RXCFG = PW'(3);
  localparam logic [PW-1:0] REG_TXCFG = PW'(5);
  localparam logic [PW-1:0] REG_MCTL = PW'(9);
  localparam logic [PW-1:0] REG_CNTLO = PW'(12);
  localparam logic [PW-1:0] REG_CNTHI = PW'(13);

  localparam logic [2:0] CMD_HI = 3'd1;
  localparam logic [2:0] CMD_CLRTX = 3'd5;
  localparam logic [2:0] CMD_RSTIUS = 3'd7;

  localparam logic [DW-1:0] RR0_RST = 8'h44;
  localparam logic [DW-1:0] RR1_RST = 8'h07;

  typedef struct packed {
    logic regWr;
    logic [PW-1:0] regIdx;
    logic dataWr;
    logic dataRd;
    logic rxTake;
    logic chanRst;
  } chStrobeT;

  typedef enum logic [1:0] {VEC_NONE, VEC_RX, VEC_TX} vecKindT;

  function automatic logic [DW-1:0] vecCode(vecKindT k, logic isA, logic hi);
    case (k)
      VEC_RX: return isA ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
      VEC_TX: return isA ? (hi ? 8'h10 : 8'h08) : 8'h00;
      default: return hi ? 8'h60 : 8'h06;
    endcase
  endfunction

  function automatic logic [DW-1:0] wrResetVal(int idx);
    case (idx)
      4: return 8'h04;
      9: return 8'hC0;
      11: return 8'h08;
      14: return 8'h30;
      15: return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/dcsr_ctrl.sv
module dcsr_ctrl
  import dcsr_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic hostSel,
  input  logic hostWrite,
  input  logic [1:0] hostAddr,
  input  logic [DW-1:0] hostWdata,
  input  logic [NCH-1:0] cfgTxIe,
  input  logic [NCH-1:0][1:0] cfgRxMode,
  input  logic [NCH-1:0] cfgShi,
  input  logic [NCH-1:0] cfgRxEn,
  input  logic [NCH-1:0] rxAvail,
  input  logic [NCH-1:0] brkTerm,
  input  logic [NCH-1:0] rxValid,
  output logic [NCH-1:0] rxReady,
  output chStrobeT [NCH-1:0] stb,
  output logic [PW-1:0] hostPtr,
  output logic [DW-1:0] vecOut,
  output logic irqOut
);
  logic [NCH-1:0][PW-1:0] ptrQ, ptrN;
  logic [NCH-1:0] rxPQ, txPQ, rxIQ, txIQ;
  logic [NCH-1:0] rxPN, txPN, rxIN, txIN;
  logic [NCH-1:0] clrTx, rstIus;
  logic [DW-1:0] vecQ, vecN;
  logic hc;
  logic [2:0] cmd;
  logic taken, setRx, setTx;

  assign hc = hostAddr[1];
  assign cmd = hostWdata[5:3];
  assign hostPtr = ptrQ[hc];
  assign vecOut = vecQ;

  // host access decode into per-channel strobes and pointer update
  always_comb begin
    stb = '0;
    ptrN = ptrQ;
    clrTx = '0;
    rstIus = '0;
    if (hostSel) begin
      if (hostAddr[0]) begin
        if (hostWrite) stb[hc].dataWr = 1'b1;
        else stb[hc].dataRd = 1'b1;
      end else if (hostWrite) begin
        if (ptrQ[hc] == '0) begin
          ptrN[hc] = {(cmd == CMD_HI), hostWdata[PW-2:0]};
          clrTx[hc] = (cmd == CMD_CLRTX);
          rstIus[hc] = (cmd == CMD_RSTIUS);
        end else begin
          ptrN[hc] = '0;
          if (ptrQ[hc] == REG_MCTL && hostWdata[7:6] != 2'b00) begin
            stb[CH_B].chanRst = hostWdata[6];
            stb[CH_A].chanRst = hostWdata[7];
          end else begin
            stb[hc].regWr = 1'b1;
            stb[hc].regIdx = ptrQ[hc];
          end
        end
      end else begin
        ptrN[hc] = '0;
      end
    end
    for (int c = 0; c < NCH; c++) begin
      if (stb[c].chanRst) ptrN[c] = '0;
    end
    // receive acceptance: channel A first, never during a host access
    taken = 1'b0;
    for (int c = NCH - 1; c >= 0; c--) begin
      rxReady[c] = cfgRxEn[c] && !rxAvail[c] && !hostSel && !taken;
      stb[c].rxTake = rxReady[c] && rxValid[c];
      taken = taken || stb[c].rxTake;
    end
  end

  // interrupt pending / under-service sequencing and vector
  always_comb begin
    rxPN = rxPQ;
    txPN = txPQ;
    rxIN = rxIQ;
    txIN = txIQ;
    vecN = vecQ;
    setRx = 1'b0;
    setTx = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      setRx = stb[c].rxTake;
      setTx = stb[c].dataWr;
      if (stb[c].chanRst) begin
        rxPN[c] = 1'b0;
        txPN[c] = 1'b0;
        rxIN[c] = 1'b0;
        txIN[c] = 1'b0;
        if (c == CH_B) vecN = '0;
        setRx = 1'b0;
        setTx = 1'b0;
      end else begin
        if (stb[c].dataRd) begin
          rxPN[c] = 1'b0;
          rxIN[c] = 1'b0;
          vecN = vecCode(VEC_NONE, c == CH_A, cfgShi[c]);
          if (txPN[c]) setTx = 1'b1;
        end
        if (clrTx[c]) begin
          txPN[c] = 1'b0;
          txIN[c] = 1'b0;
          vecN = vecCode(VEC_NONE, c == CH_A, cfgShi[c]);
          if (rxPN[c]) setRx = 1'b1;
        end
        if (rstIus[c]) begin
          if (rxIN[c]) begin
            rxIN[c] = 1'b0;
            if (txPN[c]) setTx = 1'b1;
          end else begin
            txIN[c] = 1'b0;
          end
        end
        if (setRx) begin
          rxPN[c] = 1'b1;
          rxIN[c] = 1'b1;
          vecN = vecCode(VEC_RX, c == CH_A, cfgShi[c]);
        end
        if (setTx) begin
          txPN[c] = 1'b1;
          if (!rxIN[c]) begin
            txIN[c] = 1'b1;
            vecN = vecCode(VEC_TX, c == CH_A, cfgShi[c]);
          end
        end
      end
    end
  end

  always_comb begin
    irqOut = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      irqOut = irqOut || (cfgTxIe[c] && txPQ[c])
             || ((cfgRxMode[c] == 2'b01 || cfgRxMode[c] == 2'b10) && rxPQ[c])
             || brkTerm[c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
      rxPQ <= '0;
      txPQ <= '0;
      rxIQ <= '0;
      txIQ <= '0;
      vecQ <= '0;
    end else begin
      ptrQ <= ptrN;
      rxPQ <= rxPN;
      txPQ <= txPN;
      rxIQ <= rxIN;
      txIQ <= txIN;
      vecQ <= vecN;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R7
    rx_ius_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
      rxIQ[c] |-> rxPQ[c]);
    // R9
    tx_ius_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
      txIQ[c] |-> txPQ[c]);
    // R3
    ptr_home_chk: assert property (@(posedge clk) disable iff (!rstN)
      (hostSel && !hostAddr[0] && (hostAddr[1] == (c == CH_A)) && ptrQ[c] != '0)
      |=> ptrQ[c] == '0);
    // R12
    rst_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb[c].chanRst |=> !rxPQ[c] && !txPQ[c]);
  end
endmodule

// File: rtl/dcsr_regs.sv
module dcsr_regs
  import dcsr_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  chStrobeT [NCH-1:0] stb,
  input  logic [DW-1:0] hostWdata,
  input  logic [1:0] hostAddr,
  input  logic [PW-1:0] hostPtr,
  input  logic [DW-1:0] vecIn,
  input  logic [NCH-1:0][DW-1:0] rxData,
  input  logic [NCH-1:0] rxBreak,
  output logic [DW-1:0] hostRdata,
  output logic [NCH-1:0] txValid,
  output logic [NCH-1:0][DW-1:0] txData,
  output logic [NCH-1:0] cfgTxIe,
  output logic [NCH-1:0][1:0] cfgRxMode,
  output logic [NCH-1:0] cfgShi,
  output logic [NCH-1:0] cfgRxEn,
  output logic [NCH-1:0] rxAvail,
  output logic [NCH-1:0] brkTerm
);
  logic [NCH-1:0][NREG-1:0][DW-1:0] wrQ;
  logic [NCH-1:0][DW-1:0] rr0Q, rr1Q, rr12Q, rr13Q, rxBufQ;
  logic [NCH-1:0] txValidQ;
  logic [NCH-1:0][DW-1:0] txDataQ;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int r = 0; r < NREG; r++) wrQ[c][r] <= wrResetVal(r);
        rr0Q[c] <= RR0_RST;
        rr1Q[c] <= RR1_RST;
        rr12Q[c] <= '0;
        rr13Q[c] <= '0;
        rxBufQ[c] <= '0;
        txValidQ[c] <= 1'b0;
        txDataQ[c] <= '0;
      end else begin
        txValidQ[c] <= 1'b0;
        if (stb[c].chanRst) begin
          for (int r = 0; r < NREG; r++) wrQ[c][r] <= wrResetVal(r);
          rr0Q[c] <= RR0_RST;
          rr1Q[c] <= RR1_RST;
          rr12Q[c] <= '0;
          rr13Q[c] <= '0;
          rxBufQ[c] <= '0;
        end else begin
          if (stb[c].regWr) begin
            wrQ[c][stb[c].regIdx] <= hostWdata;
            if (stb[c].regIdx == REG_CNTLO) rr12Q[c] <= hostWdata;
            if (stb[c].regIdx == REG_CNTHI) rr13Q[c] <= hostWdata;
          end
          if (stb[c].rxTake) begin
            rxBufQ[c] <= rxData[c];
            rr0Q[c][0] <= 1'b1;
          end
          if (stb[c].dataRd) rr0Q[c][0] <= 1'b0;
          if (stb[c].dataWr) begin
            rr0Q[c][2] <= 1'b1;
            rr1Q[c][0] <= 1'b1;
            txValidQ[c] <= wrQ[c][REG_TXCFG][3];
            txDataQ[c] <= hostWdata;
          end
          if (rxBreak[c]) rr0Q[c][7] <= 1'b1;
        end
      end
    end

    assign cfgTxIe[c] = wrQ[c][1][1];
    assign cfgRxMode[c] = wrQ[c][1][4:3];
    assign cfgShi[c] = wrQ[c][REG_MCTL][4];
    assign cfgRxEn[c] = wrQ[c][REG_RXCFG][0];
    assign rxAvail[c] = rr0Q[c][0];
    assign brkTerm[c] = wrQ[c][15][7] && rr0Q[c][7];

    // R4
    rx_avail_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb[c].rxTake |=> rr0Q[c][0]);
    // R6
    tx_emit_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb[c].dataWr |=> txValidQ[c] == $past(wrQ[c][REG_TXCFG][3]));
    // R12
    rst_state_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb[c].chanRst |=> rr0Q[c] == RR0_RST && wrQ[c][REG_MCTL] == 8'hC0);
  end

  assign txValid = txValidQ;
  assign txData = txDataQ;

  always_comb begin
    if (hostAddr[0]) begin
      hostRdata = rxBufQ[hostAddr[1]];
    end else begin
      case (hostPtr)
        PW'(0): hostRdata = rr0Q[hostAddr[1]];
        PW'(1): hostRdata = rr1Q[hostAddr[1]];
        PW'(2): hostRdata = (hostAddr[1] == 1'b0) ? vecIn : '0;
        REG_CNTLO: hostRdata = rr12Q[hostAddr[1]];
        REG_CNTHI: hostRdata = rr13Q[hostAddr[1]];
        default: hostRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dcsr_top.sv
module dcsr_top
  import dcsr_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic hostSel,
  input  logic hostWrite,
  input  logic [1:0] hostAddr,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  input  logic [1:0] rxValid,
  input  logic [15:0] rxData,
  output logic [1:0] rxReady,
  input  logic [1:0] rxBreak,
  output logic [1:0] txValid,
  output logic [15:0] txData,
  output logic irqOut
);
  chStrobeT [NCH-1:0] stb;
  logic [PW-1:0] hostPtr;
  logic [DW-1:0] vec;
  logic [NCH-1:0] cfgTxIe, cfgShi, cfgRxEn, rxAvail, brkTerm;
  logic [NCH-1:0][1:0] cfgRxMode;
  logic [NCH-1:0][DW-1:0] rxArr, txArr;

  assign rxArr = rxData;
  assign txData = txArr;

  dcsr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .cfgTxIe(cfgTxIe),
    .cfgRxMode(cfgRxMode), .cfgShi(cfgShi), .cfgRxEn(cfgRxEn),
    .rxAvail(rxAvail), .brkTerm(brkTerm), .rxValid(rxValid),
    .rxReady(rxReady), .stb(stb), .hostPtr(hostPtr), .vecOut(vec),
    .irqOut(irqOut)
  );

  dcsr_regs i_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWdata(hostWdata),
    .hostAddr(hostAddr), .hostPtr(hostPtr), .vecIn(vec), .rxData(rxArr),
    .rxBreak(rxBreak), .hostRdata(hostRdata), .txValid(txValid),
    .txData(txArr), .cfgTxIe(cfgTxIe), .cfgRxMode(cfgRxMode),
    .cfgShi(cfgShi), .cfgRxEn(cfgRxEn), .rxAvail(rxAvail), .brkTerm(brkTerm)
  );
endmodule

// File: tb/test_dcsr_top.sv
module test_dcsr_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 1'b0, hostWrite = 1'b0;
  logic [1:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic [1:0] rxValid = '0, rxBreak = '0, rxReady, txValid;
  logic [15:0] rxData = '0, txData;
  logic irqOut;
  int total = 0, bad = 0;
  logic [7:0] rdExpQ[$];
  string rdTagQ[$];
  logic [7:0] txExpQ[$];
  int txChQ[$];

  always #2 clk = ~clk;

  dcsr_top i_dcsr_top (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady), .rxBreak(rxBreak),
    .txValid(txValid), .txData(txData), .irqOut(irqOut)
  );

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(int ch, bit isData, bit wr, logic [7:0] d);
    @(posedge clk); #1;
    hostSel = 1'b1; hostWrite = wr; hostAddr = {ch[0], isData}; hostWdata = d;
    @(posedge clk); #1;
    hostSel = 1'b0;
  endtask

  task automatic ctrlWr(int ch, int rg, logic [7:0] v);
    if (rg != 0) access(ch, 1'b0, 1'b1, {2'b00, (rg >= 8) ? 3'd1 : 3'd0, 3'(rg)});
    access(ch, 1'b0, 1'b1, v);
  endtask

  task automatic ctrlRd(int ch, int rg, logic [7:0] exp, string tag);
    if (rg != 0) access(ch, 1'b0, 1'b1, {2'b00, (rg >= 8) ? 3'd1 : 3'd0, 3'(rg)});
    rdExpQ.push_back(exp); rdTagQ.push_back(tag);
    access(ch, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic dataWr(int ch, logic [7:0] v, bit emitted);
    if (emitted) begin txExpQ.push_back(v); txChQ.push_back(ch); end
    access(ch, 1'b1, 1'b1, v);
  endtask

  task automatic dataRd(int ch, logic [7:0] exp, string tag);
    rdExpQ.push_back(exp); rdTagQ.push_back(tag);
    access(ch, 1'b1, 1'b0, 8'h00);
  endtask

  task automatic rxSend(int ch, logic [7:0] b);
    @(posedge clk); #1;
    rxValid[ch] = 1'b1; rxData[ch*8 +: 8] = b;
    @(negedge clk);
    for (int i = 0; i < 20 && !rxReady[ch]; i++) @(negedge clk);
    @(posedge clk); #1;
    rxValid[ch] = 1'b0;
  endtask

  task automatic sampleIrq(bit exp, string tag);
    @(negedge clk);
    chk(irqOut == exp, tag, {7'd0, irqOut}, {7'd0, exp});
  endtask

  // read-data monitor
  initial forever begin
    @(negedge clk);
    if (hostSel && !hostWrite) begin
      if (rdExpQ.size() == 0) chk(1'b0, "R3 unexpected read", hostRdata, 8'h00);
      else begin
        logic [7:0] e;
        string t;
        e = rdExpQ.pop_front(); t = rdTagQ.pop_front();
        chk(hostRdata == e, t, hostRdata, e);
      end
    end
  end

  // transmit monitor
  initial forever begin
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      if (txValid[c]) begin
        if (txExpQ.size() == 0) chk(1'b0, "R6 unexpected tx", txData[c*8 +: 8], 8'h00);
        else begin
          logic [7:0] e;
          int ec;
          e = txExpQ.pop_front(); ec = txChQ.pop_front();
          chk(ec == c && txData[c*8 +: 8] == e, "R6 tx byte", txData[c*8 +: 8], e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // reset state, R12
    sampleIrq(1'b0, "R11 irq low after reset");
    ctrlRd(0, 0, 8'h44, "R12 B RR0 reset");
    ctrlRd(1, 1, 8'h07, "R12 A RR1 reset");
    ctrlRd(0, 2, 8'h00, "R10 vector after reset");
    // pointer and register mirror, R1 R2 R3
    ctrlWr(1, 12, 8'h5A);
    ctrlWr(0, 13, 8'hC3);
    ctrlRd(1, 12, 8'h5A, "R2 A RR12 mirror");
    ctrlRd(1, 0, 8'h44, "R3 pointer back to 0");
    ctrlRd(0, 13, 8'hC3, "R3 B RR13 mirror");
    ctrlRd(0, 12, 8'h00, "R1 B RR12 separate");
    ctrlRd(1, 2, 8'h00, "R3 A RR2 reads 0");
    // receive on A, R4 R5 R10 R11
    @(negedge clk);
    chk(rxReady[1] == 1'b0, "R4 ready low with WR3 off", {7'd0, rxReady[1]}, 8'h00);
    ctrlWr(1, 3, 8'h01);
    ctrlWr(1, 1, 8'h10);
    rxSend(1, 8'h3C);
    sampleIrq(1'b1, "R11 rx irq");
    ctrlRd(0, 2, 8'h0C, "R10 rx A code");
    ctrlRd(1, 0, 8'h45, "R4 A RR0 avail");
    @(negedge clk);
    chk(rxReady[1] == 1'b0, "R4 ready low while avail", {7'd0, rxReady[1]}, 8'h00);
    dataRd(1, 8'h3C, "R5 A data read");
    ctrlRd(1, 0, 8'h44, "R5 avail cleared");
    sampleIrq(1'b0, "R5 irq cleared");
    ctrlRd(0, 2, 8'h06, "R5 vector none");
    // transmit on A, R6 R8 R11
    dataWr(1, 8'h11, 1'b0);
    sampleIrq(1'b0, "R11 tx masked by WR1");
    ctrlRd(0, 2, 8'h08, "R10 tx A code");
    ctrlWr(1, 1, 8'h12);
    sampleIrq(1'b1, "R11 tx irq enabled");
    access(1, 1'b0, 1'b1, 8'h28);
    sampleIrq(1'b0, "R8 tx cleared");
    ctrlRd(0, 2, 8'h06, "R8 vector none");
    ctrlWr(1, 5, 8'h08);
    dataWr(1, 8'h9E, 1'b1);
    access(1, 1'b0, 1'b1, 8'h28);
    // channel B ordering, R7 R9 R5 R8
    ctrlWr(0, 3, 8'h01);
    ctrlWr(0, 1, 8'h12);
    rxSend(0, 8'h77);
    ctrlRd(0, 2, 8'h04, "R10 rx B code");
    dataWr(0, 8'hAB, 1'b0);
    ctrlRd(0, 2, 8'h04, "R7 tx held off by rx IUS");
    access(0, 1'b0, 1'b1, 8'h38);
    ctrlRd(0, 2, 8'h00, "R9 tx B after IUS reset");
    sampleIrq(1'b1, "R9 irq still pending");
    dataRd(0, 8'h77, "R5 B data read");
    ctrlRd(0, 2, 8'h00, "R5 tx B re-raised");
    sampleIrq(1'b1, "R11 tx B pending");
    access(0, 1'b0, 1'b1, 8'h28);
    ctrlRd(0, 2, 8'h06, "R8 B cleared");
    sampleIrq(1'b0, "R11 all clear");
    rxSend(0, 8'h55);
    dataWr(0, 8'h5B, 1'b0);
    access(0, 1'b0, 1'b1, 8'h28);
    ctrlRd(0, 2, 8'h04, "R8 rx re-marked");
    sampleIrq(1'b1, "R8 rx irq kept");
    dataRd(0, 8'h55, "R5 B second byte");
    sampleIrq(1'b0, "R5 irq low");
    // status-high codes, R10
    ctrlWr(0, 9, 8'h10);
    rxSend(0, 8'h01);
    ctrlRd(0, 2, 8'h20, "R10 rx B high code");
    dataRd(0, 8'h01, "R5 B third byte");
    ctrlRd(0, 2, 8'h60, "R10 none high code");
    ctrlWr(1, 9, 8'h10);
    rxSend(1, 8'h02);
    ctrlRd(0, 2, 8'h30, "R10 rx A high code");
    dataWr(1, 8'h33, 1'b1);
    ctrlRd(0, 2, 8'h30, "R7 A tx held off");
    dataRd(1, 8'h02, "R5 A second byte");
    ctrlRd(0, 2, 8'h10, "R10 tx A high code");
    access(1, 1'b0, 1'b1, 8'h28);
    ctrlRd(0, 2, 8'h60, "R8 A none high");
    // simultaneous bytes, R4
    @(posedge clk); #1;
    rxValid = 2'b11; rxData = {8'hA1, 8'hB2};
    @(negedge clk);
    chk(rxReady == 2'b10, "R4 A served first", {6'd0, rxReady}, 8'h02);
    @(negedge clk);
    chk(rxReady == 2'b01, "R4 B served next", {6'd0, rxReady}, 8'h01);
    @(posedge clk); #1;
    rxValid = 2'b00;
    ctrlRd(0, 2, 8'h20, "R4 last accepted B");
    dataRd(1, 8'hA1, "R4 A byte");
    dataRd(0, 8'hB2, "R4 B byte");
    ctrlRd(0, 2, 8'h60, "R5 vector none");
    sampleIrq(1'b0, "R11 quiet");
    // break, R13
    @(posedge clk); #1 rxBreak = 2'b01;
    @(posedge clk); #1 rxBreak = 2'b00;
    sampleIrq(1'b1, "R13 break irq");
    ctrlRd(0, 0, 8'hC4, "R13 B RR0 break");
    // channel resets, R12
    ctrlWr(1, 9, 8'h40);
    ctrlRd(0, 0, 8'h44, "R12 B RR0 after reset");
    sampleIrq(1'b0, "R12 irq after B reset");
    ctrlRd(0, 2, 8'h00, "R12 vector cleared");
    ctrlRd(1, 12, 8'h5A, "R12 A untouched");
    @(negedge clk);
    chk(rxReady[0] == 1'b0, "R12 B WR3 cleared", {7'd0, rxReady[0]}, 8'h00);
    ctrlWr(0, 9, 8'hC0);
    ctrlRd(1, 12, 8'h00, "R12 A reset by both");
    ctrlRd(1, 0, 8'h44, "R12 A RR0 after both");
    repeat (4) @(posedge clk);
    chk(rdExpQ.size() == 0 && txExpQ.size() == 0, "R6 queues drained",
        8'(txExpQ.size()), 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule